// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block sequences the addresses for one DMA channel that walks a rectangular buffer. Software programs a start address, the number of transfers in a row, the number of rows, and two signed byte steps: one applied between elements of the same row and one applied after the last element of a row. While enabled, the block offers one address at a time on a ready/valid handshake. When the row step differs from the element step, a single program can write a sub-rectangle into a wider frame buffer. For example, a 10-pixel-wide patch of 3-byte pixels in a 480-pixel frame, moved as 16-bit words, uses 15 transfers per row, an element step of 2 and a row step of (480-10)*3+2.

The walk is controlled by a small state machine with four named states. `ST_IDLE` waits for enable. `ST_WALK` issues addresses. `ST_DONE` holds after a single pass has finished. `ST_FAULT` holds after an enable with an illegal zero count. The transitions are:

- `ST_IDLE` to `ST_WALK` on enable with both counts non-zero.
- `ST_IDLE` to `ST_FAULT` on enable with a zero count.
- `ST_WALK` to `ST_DONE` when the final element is accepted in single-pass mode.
- `ST_WALK` to `ST_IDLE` when enable is dropped.
- `ST_DONE` or `ST_FAULT` to `ST_IDLE` when enable is dropped.

In autobuffer mode the walk never leaves `ST_WALK` on its own: after the final element it restarts from the start address. Two instances, one for the source and one for the destination, can be paired to drive a memory-to-memory rectangular copy.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `run`, `done` and `error` are all 0.
- R2: When `enable` is sampled high in `ST_IDLE` with both counts non-zero, `addr_valid` and `run` are 1 from the next cycle, and the first address offered equals `cfg_start`.
- R3: Within a row, each accepted transfer (`addr_valid` and `addr_ready` both 1 at a clock edge) advances the address by `cfg_x_mod`, read as a signed two's-complement byte step.
- R4: Accepting the last element of a row that is not the final row advances the address by the signed `cfg_y_mod` instead of `cfg_x_mod`.
- R5: While `addr_valid` is 1 and `addr_ready` is 0, the offered address and `addr_valid` stay unchanged.
- R6: With `autobuf` = 0, accepting the final element of the final row clears `addr_valid` and `run` and sets `done` in the next cycle. No further address is offered until `enable` goes low and then high again.
- R7: With `autobuf` = 1, accepting the final element is followed at once by the start address again, `addr_valid` stays 1, and `done` stays 0.
- R8: An enable with `cfg_x_count` = 0 or `cfg_y_count` = 0 sets `error` and offers no address; `run` stays 0.
- R9: Writing 1 to `clr_done` or `clr_error` clears that bit in the next cycle. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: A clock edge that samples `enable` low leaves `addr_valid` and `run` at 0 from the next cycle. A later enable restarts the walk from the `cfg_start` value present at that enable.
- R11: Changes to any `cfg_*` input or to `autobuf` during a walk have no effect on the addresses until the next start from `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable, level sensitive |
| autobuf | input | 1 | 1 = restart after the final element, 0 = single pass |
| cfg_start | input | ADDR_W | Start address |
| cfg_x_count | input | CNT_W | Transfers per row |
| cfg_x_mod | input | MOD_W | Signed byte step between elements of a row |
| cfg_y_count | input | CNT_W | Number of rows |
| cfg_y_mod | input | MOD_W | Signed byte step after the last element of a row |
| clr_done | input | 1 | Write-one-to-clear strobe for `done` |
| clr_error | input | 1 | Write-one-to-clear strobe for `error` |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_out | output | ADDR_W | Offered address |
| run | output | 1 | Walk in progress |
| done | output | 1 | Single pass completed (sticky) |
| error | output | 1 | Enable seen with a zero count (sticky) |

## Verification
Two pairs of events can fall in the same cycle. In the first, the acceptance of the final element, which sets `done`, coincides with a `clr_done` strobe. In the second, an enable with a zero count, which sets `error`, coincides with a `clr_error` strobe. The bench raises `clr_done` on exactly the negative edge where it grants `addr_ready` to the last element. It raises `clr_error` together with the faulty enable. In both cases it expects the status bit to read 1 afterwards and to drop only after a separate, lone clear strobe.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } walk_state_e;
endpackage

// File: rtl/dma2d_walk_cnt.sv
// Element and row position tracker for the 2D walk.
module dma2d_walk_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] x_count,
    input  logic [CNT_W-1:0] y_count,
    output logic             row_end,
    output logic             last_elem
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] x_idx;
    logic [CNT_W-1:0] y_idx;

    assign row_end   = (x_idx == (x_count - ONE));
    assign last_elem = row_end && (y_idx == (y_count - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_idx <= '0;
            y_idx <= '0;
        end else if (load) begin
            x_idx <= '0;
            y_idx <= '0;
        end else if (step) begin
            if (row_end) begin
                x_idx <= '0;
                y_idx <= last_elem ? '0 : y_idx + ONE;
            end else begin
                x_idx <= x_idx + ONE;
            end
        end
    end

    // Steps only happen while the walk sits inside the programmed rectangle
    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (x_idx < x_count) && (y_idx < y_count));
endmodule

// File: rtl/dma2d_addr_step.sv
// Address register with signed element / row stepping.
module dma2d_addr_step #(
    parameter int ADDR_W = 32,
    parameter int MOD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              row_end,
    input  logic [MOD_W-1:0]  x_mod,
    input  logic [MOD_W-1:0]  y_mod,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - MOD_W;

    logic [MOD_W-1:0]  sel_mod;
    logic [ADDR_W-1:0] step_ext;

    assign sel_mod  = row_end ? y_mod : x_mod;
    assign step_ext = {{EXT_W{sel_mod[MOD_W-1]}}, sel_mod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + step_ext;
        end
    end

    p_load_takes_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(load_val));
endmodule

// File: rtl/dma2d_status.sv
// Sticky done / error bits, write-one-to-clear, set has priority.
module dma2d_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic done,
    output logic err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (set_done)      done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (set_err)       err  <= 1'b1;
            else if (clr_err)  err  <= 1'b0;
        end
    end

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_done && clr_done) |=> done);
    p_clear_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !set_err) |=> !err);
endmodule

// File: rtl/dma2d_addr_gen.sv
// Two-dimensional DMA address sequencer, top level.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int MOD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              autobuf,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_x_count,
    input  logic [MOD_W-1:0]  cfg_x_mod,
    input  logic [CNT_W-1:0]  cfg_y_count,
    input  logic [MOD_W-1:0]  cfg_y_mod,
    input  logic              clr_done,
    input  logic              clr_error,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_out,
    output logic              run,
    output logic              done,
    output logic              error
);
    localparam int EXT_W = ADDR_W - MOD_W;

    walk_state_e state_q, state_d;

    // Program snapshot taken at start
    logic [ADDR_W-1:0] snap_start;
    logic [CNT_W-1:0]  snap_xcnt, snap_ycnt;
    logic [MOD_W-1:0]  snap_xmod, snap_ymod;
    logic              snap_auto;

    logic counts_ok, accept, row_end, last_elem;
    logic load_fresh, reload, load_walk, step_walk;
    logic set_done, set_err;
    logic [ADDR_W-1:0] load_val;

    assign counts_ok = (cfg_x_count != '0) && (cfg_y_count != '0);
    assign accept    = (state_q == ST_WALK) && addr_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = counts_ok ? ST_WALK : ST_FAULT;
            end
            ST_WALK: begin
                if (!enable)
                    state_d = ST_IDLE;
                else if (accept && last_elem && !snap_auto)
                    state_d = ST_DONE;
            end
            ST_DONE, ST_FAULT: begin
                if (!enable) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        addr_valid = 1'b0;
        run        = 1'b0;
        load_fresh = 1'b0;
        reload     = 1'b0;
        set_done   = 1'b0;
        set_err    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_fresh = enable && counts_ok;
                set_err    = enable && !counts_ok;
            end
            ST_WALK: begin
                addr_valid = 1'b1;
                run        = 1'b1;
                reload     = accept && last_elem && snap_auto;
                set_done   = accept && last_elem && !snap_auto;
            end
            ST_DONE, ST_FAULT: ;
            default: ;
        endcase
    end

    assign load_walk = load_fresh || reload;
    assign step_walk = accept && !reload;
    assign load_val  = (state_q == ST_IDLE) ? cfg_start : snap_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_start <= '0;
            snap_xcnt  <= '0;
            snap_ycnt  <= '0;
            snap_xmod  <= '0;
            snap_ymod  <= '0;
            snap_auto  <= 1'b0;
        end else if (load_fresh) begin
            snap_start <= cfg_start;
            snap_xcnt  <= cfg_x_count;
            snap_ycnt  <= cfg_y_count;
            snap_xmod  <= cfg_x_mod;
            snap_ymod  <= cfg_y_mod;
            snap_auto  <= autobuf;
        end
    end

    dma2d_walk_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_walk),
        .step      (step_walk),
        .x_count   (snap_xcnt),
        .y_count   (snap_ycnt),
        .row_end   (row_end),
        .last_elem (last_elem)
    );

    dma2d_addr_step #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_walk),
        .load_val (load_val),
        .step     (step_walk),
        .row_end  (row_end),
        .x_mod    (snap_xmod),
        .y_mod    (snap_ymod),
        .addr     (addr_out)
    );

    dma2d_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (set_done),
        .set_err  (set_err),
        .clr_done (clr_done),
        .clr_err  (clr_error),
        .done     (done),
        .err      (error)
    );

    // Assertions
    logic [ADDR_W-1:0] xmod_ext, ymod_ext;
    assign xmod_ext = {{EXT_W{snap_xmod[MOD_W-1]}}, snap_xmod};
    assign ymod_ext = {{EXT_W{snap_ymod[MOD_W-1]}}, snap_ymod};

    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && enable) |=> addr_valid && $stable(addr_out));
    p_elem_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready && enable && !row_end)
            |=> addr_out == $past(addr_out) + $past(xmod_ext));
    p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready && enable && row_end && !last_elem)
            |=> addr_out == $past(addr_out) + $past(ymod_ext));
    p_done_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(addr_valid && addr_ready));
    p_no_issue_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> !addr_valid && !run);
    p_stop_on_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !addr_valid && !run);
endmodule

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb_top;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int MOD_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              autobuf = 1'b0;
    logic [ADDR_W-1:0] cfg_start = '0;
    logic [CNT_W-1:0]  cfg_x_count = '0;
    logic [MOD_W-1:0]  cfg_x_mod = '0;
    logic [CNT_W-1:0]  cfg_y_count = '0;
    logic [MOD_W-1:0]  cfg_y_mod = '0;
    logic              clr_done = 1'b0;
    logic              clr_error = 1'b0;
    logic              addr_ready = 1'b0;
    logic              addr_valid, run, done, error;
    logic [ADDR_W-1:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .autobuf(autobuf),
        .cfg_start(cfg_start), .cfg_x_count(cfg_x_count), .cfg_x_mod(cfg_x_mod),
        .cfg_y_count(cfg_y_count), .cfg_y_mod(cfg_y_mod),
        .clr_done(clr_done), .clr_error(clr_error),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
        .run(run), .done(done), .error(error)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [31:0] st, int xc, int xm, int ym, int k);
        int ix = k % xc;
        int iy = k / xc;
        longint off = longint'(iy) * (longint'(xc - 1) * xm + ym) + longint'(ix) * xm;
        return st + off[31:0];
    endfunction

    task automatic scramble_cfg();
        cfg_start   = $urandom;
        cfg_x_count = CNT_W'($urandom_range(0, 9));
        cfg_y_count = CNT_W'($urandom_range(0, 9));
        cfg_x_mod   = MOD_W'($urandom);
        cfg_y_mod   = MOD_W'($urandom);
        autobuf     = ~autobuf;
    endtask

    // Runs one walk; single pass or two autobuffer passes.
    task automatic run_walk(input logic [31:0] st, input int xc, input int yc,
                            input int xm, input int ym, input bit au,
                            input int pct, input bit collide);
        int total  = xc * yc;
        int target = au ? 2 * total : total;
        int k = 0;
        int idle = 0;
        bit stalled = 0;
        bit first = 1;
        string tag;
        @(negedge clk);
        cfg_start = st; cfg_x_count = CNT_W'(xc); cfg_y_count = CNT_W'(yc);
        cfg_x_mod = MOD_W'(xm); cfg_y_mod = MOD_W'(ym); autobuf = au;
        enable = 1'b1; addr_ready = 1'b0;
        while (k < target && idle < 50) begin
            @(negedge clk);
            clr_done = 1'b0;
            scramble_cfg();   // R11: must not disturb this walk
            if (addr_valid) begin
                idle = 0;
                if (first)                           tag = "R2";
                else if (stalled)                    tag = "R5";
                else if (k % total == 0)             tag = "R7";
                else if ((k % total) % xc == 0)      tag = "R4";
                else                                 tag = "R3";
                chk(addr_out == exp_addr(st, xc, xm, ym, k % total), {tag, " R11 addr"},
                    addr_out, exp_addr(st, xc, xm, ym, k % total));
                if (first) chk(run == 1'b1, "R2 run", run, 1);
                first = 0;
                addr_ready = ($urandom_range(0, 99) < pct);
                stalled = !addr_ready;
                if (addr_ready) begin
                    if (collide && !au && k == target - 1) clr_done = 1'b1;
                    k++;
                end
            end else begin
                addr_ready = 1'b0;
                idle++;
            end
        end
        chk(idle < 50, "R2 progress", idle, 0);
        @(negedge clk);
        addr_ready = 1'b0;
        clr_done = 1'b0;
        if (!au) begin
            chk(addr_valid == 1'b0 && run == 1'b0, "R6 stop", {addr_valid, run}, 0);
            chk(done == 1'b1, collide ? "R9 set wins over clr_done" : "R6 done", done, 1);
            addr_ready = 1'b1;
            repeat (2) @(negedge clk);
            chk(addr_valid == 1'b0, "R6 no reissue", addr_valid, 0);
            addr_ready = 1'b0;
            clr_done = 1'b1;
            @(negedge clk);
            clr_done = 1'b0;
            @(negedge clk);
            chk(done == 1'b0, "R9 clear done", done, 0);
        end else begin
            chk(addr_valid == 1'b1 && addr_out == st, "R7 restart", addr_out, st);
            chk(done == 1'b0, "R7 no done", done, 0);
        end
        enable = 1'b0;
        @(negedge clk);
        chk(addr_valid == 1'b0 && run == 1'b0, "R10 disable", {addr_valid, run}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({addr_valid, run, done, error} == 4'b0, "R1 in reset", {addr_valid, run, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({addr_valid, run, done, error} == 4'b0, "R1 after reset", {addr_valid, run, done, error}, 0);

        // Contiguous line walk: 360 words of 4 bytes, 3 rows
        run_walk(32'h1000_0000, 360, 3, 4, 4, 1'b0, 100, 1'b0);
        // Sub-rectangle blit into a 480x3-byte frame, 10x4 patch at (7,5)
        run_walk(32'h2000_0000 + (7 & ~1) * 3 + 5 * 480 * 3, 15, 4, 2, (480 - 10) * 3 + 2,
                 1'b0, 70, 1'b0);
        // Single element, and single-column walks
        run_walk(32'h0000_0100, 1, 1, 8, -8, 1'b0, 100, 1'b0);
        run_walk(32'h0000_0200, 1, 5, 8, -16, 1'b0, 50, 1'b0);
        // Done set and clr_done in the same cycle
        run_walk(32'h0000_0300, 2, 1, 4, 4, 1'b0, 100, 1'b1);

        // Random walks
        for (int i = 0; i < 30; i++) begin
            run_walk($urandom, $urandom_range(1, 6), $urandom_range(1, 5),
                     int'($urandom_range(0, 128)) - 64, int'($urandom_range(0, 128)) - 64,
                     1'($urandom_range(0, 1)), 60, 1'($urandom_range(0, 1)));
        end

        // Zero count with clr_error colliding
        @(negedge clk);
        cfg_start = 32'h55; cfg_x_count = '0; cfg_y_count = CNT_W'(3);
        enable = 1'b1; clr_error = 1'b1;
        @(negedge clk);
        clr_error = 1'b0;
        chk(error == 1'b1, "R9 set wins over clr_error", error, 1);
        repeat (3) begin
            chk(addr_valid == 1'b0 && run == 1'b0, "R8 x zero no issue", {addr_valid, run}, 0);
            @(negedge clk);
        end
        enable = 1'b0;
        clr_error = 1'b1;
        @(negedge clk);
        clr_error = 1'b0;
        @(negedge clk);
        chk(error == 1'b0, "R9 clear error", error, 0);
        cfg_x_count = CNT_W'(4); cfg_y_count = '0; enable = 1'b1;
        @(negedge clk);
        chk(error == 1'b1 && addr_valid == 1'b0, "R8 y zero", {error, addr_valid}, 2'b10);
        enable = 1'b0;
        @(negedge clk);

        // Abort mid-walk and restart from a new start address
        cfg_start = 32'hA000; cfg_x_count = CNT_W'(4); cfg_y_count = CNT_W'(4);
        cfg_x_mod = MOD_W'(4); cfg_y_mod = MOD_W'(4); autobuf = 1'b0;
        enable = 1'b1; addr_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(addr_out == 32'hA00C, "R3 before abort", addr_out, 32'hA00C);
        enable = 1'b0; addr_ready = 1'b0;
        @(negedge clk);
        chk(addr_valid == 1'b0 && run == 1'b0 && done == 1'b0, "R10 abort", {addr_valid, run, done}, 0);
        cfg_start = 32'hB000; enable = 1'b1;
        @(negedge clk);
        chk(addr_valid == 1'b1 && addr_out == 32'hB000, "R10 restart", addr_out, 32'hB000);
        enable = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule